// File: doc/BRIEF.md
# GPIO Bank Register Block

This block is the register side of a bank of up to 32 general-purpose pins. A simple word-wide bus (address, write enable, write data, combinational read data) programs per-pin state: whether the pin is plain I/O or feeds an interrupt unit, whether it drives, what value it drives, and whether its logic sense is inverted. Each register holds one bit per pin.

Pad inputs are synchronised through a two-flop chain and presented, after the polarity inversion, in a read-only input register. Interrupt sensing itself lives in a separate unit. This block hands that unit the per-pin mode, polarity, edge/level and both-edge bits as plain vectors. It also passes on one-cycle strobe vectors when software writes the clear, mask-write or mask-clear words. The interrupt unit returns status and mask vectors, and this block reads them back through the bus. A debounce-enable word is stored and read back but changes nothing.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every stored register reads 0, pad_oe_o is 0 and pad_o is 0.
- R2: Full-word writes at the mode (0x00), direction (0x04), output data (0x08), polarity (0x20), edge/level (0x24), debounce (0x28), drive select (0x40) and both-edge (0x4C) offsets are read back unchanged from the same offsets. Writes to other offsets leave these registers alone.
- R3: pad_oe_o for a pin is 1 only when its mode bit is 0 (general I/O) and its direction bit is 1 (output). A mode bit of 1 (interrupt input) never drives.
- R4: pad_o equals the output data bit when the drive select bit is 0. A drive select bit of 1 holds pad_o low.
- R5: The input register at 0x0C reads pad_i XOR polarity. A polarity bit of 1 selects negative logic. A pad change made before clock edge k shows up after edge k+1.
- R6: Writes to the input register at 0x0C are ignored.
- R7: A write to 0x14 (clear), 0x18 (mask write) or 0x1C (mask clear) puts the write data on irq_clr_o, irq_msk_wr_o or irq_msk_clr_o respectively for exactly the one cycle after the write edge. At all other times these outputs are 0.
- R8: Reads at 0x10 return irq_status_i and reads at 0x18 return irq_mask_i.
- R9: irq_mode_o, irq_invert_o, irq_edge_o and irq_both_o equal the mode, polarity, edge/level and both-edge registers.
- R10: The debounce register has no effect on pad_o, pad_oe_o or the input register.
- R11: A read of any unmapped offset returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write enable, sampled on the rising edge |
| bus_addr_i | input | 8 | Byte offset of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| pad_i | input | N_PINS | Raw pad input levels |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables |
| irq_mode_o | output | N_PINS | Per-pin interrupt-input mode bits |
| irq_invert_o | output | N_PINS | Per-pin negative-logic bits |
| irq_edge_o | output | N_PINS | Per-pin edge/level select bits |
| irq_both_o | output | N_PINS | Per-pin both-edge bits |
| irq_clr_o | output | N_PINS | One-cycle clear strobe vector |
| irq_msk_wr_o | output | N_PINS | One-cycle mask-write strobe vector |
| irq_msk_clr_o | output | N_PINS | One-cycle mask-clear strobe vector |
| irq_status_i | input | N_PINS | Status from the interrupt unit |
| irq_mask_i | input | N_PINS | Mask from the interrupt unit |

## Verification
Read data is combinational, so the bench samples it in the same low phase in which it sets the address. A register write takes effect on the write edge, so pad enables, pad values, configuration vectors and read-back are checked at the falling edge right after it. The strobe vectors are checked at that same falling edge and again one cycle later, where they must be back to 0. A pad change reaches the input register only after the second rising edge, so the bench checks that it is still hidden after one edge and visible after two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE   = 8'h00,
    OFS_DIR    = 8'h04,
    OFS_DOUT   = 8'h08,
    OFS_DIN    = 8'h0C,
    OFS_ISTAT  = 8'h10,
    OFS_ICLR   = 8'h14,
    OFS_IMSK   = 8'h18,
    OFS_IUNMSK = 8'h1C,
    OFS_POL    = 8'h20,
    OFS_TRIG   = 8'h24,
    OFS_DEB    = 8'h28,
    OFS_DSEL   = 8'h40,
    OFS_BOTH   = 8'h4C
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assert_sync_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      dout_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      trig_o,
  output logic [N-1:0]      deb_o,
  output logic [N-1:0]      dsel_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      clr_stb_o,
  output logic [N-1:0]      mwr_stb_o,
  output logic [N-1:0]      mclr_stb_o
);
  logic [N-1:0] wd;
  assign wd = wdata_i[N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0; dir_o  <= '0; dout_o <= '0; pol_o  <= '0;
      trig_o <= '0; deb_o  <= '0; dsel_o <= '0; both_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_MODE: mode_o <= wd;
        OFS_DIR:  dir_o  <= wd;
        OFS_DOUT: dout_o <= wd;
        OFS_POL:  pol_o  <= wd;
        OFS_TRIG: trig_o <= wd;
        OFS_DEB:  deb_o  <= wd;
        OFS_DSEL: dsel_o <= wd;
        OFS_BOTH: both_o <= wd;
        default: ;
      endcase
    end
  end

  // strobes: one cycle, carry the written word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_stb_o <= '0; mwr_stb_o <= '0; mclr_stb_o <= '0;
    end else begin
      clr_stb_o  <= (we_i && addr_i == OFS_ICLR)   ? wd : '0;
      mwr_stb_o  <= (we_i && addr_i == OFS_IMSK)   ? wd : '0;
      mclr_stb_o <= (we_i && addr_i == OFS_IUNMSK) ? wd : '0;
    end
  end

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_DIR) |=> $stable(dir_o));
  assert_mode_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_MODE) |=> $stable(mode_o));
  assert_clr_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_ICLR) |=> (clr_stb_o == '0));
  assert_stb_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|clr_stb_o, |mwr_stb_o, |mclr_stb_o}));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] dout_i,
  input  logic [N-1:0] dsel_i,
  output logic [N-1:0] pad_o,
  output logic [N-1:0] pad_oe_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    assign pad_oe_o[p] = ~mode_i[p] & dir_i[p];
    assign pad_o[p]    = dsel_i[p] ? 1'b0 : dout_i[p];
  end

  assert_no_irq_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & mode_i) == '0);
  assert_oe_needs_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_i) == '0);
  assert_sel_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & dsel_i) == '0);
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      mode_i,
  input  logic [N-1:0]      dir_i,
  input  logic [N-1:0]      dout_i,
  input  logic [N-1:0]      din_i,
  input  logic [N-1:0]      istat_i,
  input  logic [N-1:0]      imsk_i,
  input  logic [N-1:0]      pol_i,
  input  logic [N-1:0]      trig_i,
  input  logic [N-1:0]      deb_i,
  input  logic [N-1:0]      dsel_i,
  input  logic [N-1:0]      both_i,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [N-1:0] sel;
  logic         hit;

  always_comb begin
    hit = 1'b1;
    unique case (addr_i)
      OFS_MODE:  sel = mode_i;
      OFS_DIR:   sel = dir_i;
      OFS_DOUT:  sel = dout_i;
      OFS_DIN:   sel = din_i;
      OFS_ISTAT: sel = istat_i;
      OFS_IMSK:  sel = imsk_i;
      OFS_POL:   sel = pol_i;
      OFS_TRIG:  sel = trig_i;
      OFS_DEB:   sel = deb_i;
      OFS_DSEL:  sel = dsel_i;
      OFS_BOTH:  sel = both_i;
      default: begin sel = '0; hit = 1'b0; end
    endcase
  end

  assign rdata_o = BUS_W'(sel);

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));
  assert_status_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_ISTAT) |-> (rdata_o == BUS_W'(istat_i)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] irq_mode_o,
  output logic [N_PINS-1:0] irq_invert_o,
  output logic [N_PINS-1:0] irq_edge_o,
  output logic [N_PINS-1:0] irq_both_o,
  output logic [N_PINS-1:0] irq_clr_o,
  output logic [N_PINS-1:0] irq_msk_wr_o,
  output logic [N_PINS-1:0] irq_msk_clr_o,
  input  logic [N_PINS-1:0] irq_status_i,
  input  logic [N_PINS-1:0] irq_mask_i
);
  logic [N_PINS-1:0] mode, dir, dout, pol, trig, deb, dsel, both;
  logic [N_PINS-1:0] pad_sync, din;

  gpio_cfg_regs #(.N(N_PINS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .mode_o(mode), .dir_o(dir), .dout_o(dout), .pol_o(pol),
    .trig_o(trig), .deb_o(deb), .dsel_o(dsel), .both_o(both),
    .clr_stb_o(irq_clr_o), .mwr_stb_o(irq_msk_wr_o), .mclr_stb_o(irq_msk_clr_o)
  );

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_sync)
  );

  assign din = pad_sync ^ pol;

  gpio_pad_ctrl #(.N(N_PINS)) u_pad (
    .clk_i, .rst_ni,
    .mode_i(mode), .dir_i(dir), .dout_i(dout), .dsel_i(dsel),
    .pad_o, .pad_oe_o
  );

  gpio_rd_mux #(.N(N_PINS)) u_rd (
    .clk_i, .rst_ni, .addr_i(bus_addr_i),
    .mode_i(mode), .dir_i(dir), .dout_i(dout), .din_i(din),
    .istat_i(irq_status_i), .imsk_i(irq_mask_i), .pol_i(pol),
    .trig_i(trig), .deb_i(deb), .dsel_i(dsel), .both_i(both),
    .rdata_o(bus_rdata_o)
  );

  assign irq_mode_o   = mode;
  assign irq_invert_o = pol;
  assign irq_edge_o   = trig;
  assign irq_both_o   = both;
endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, i_mode, i_inv, i_edge, i_both, i_clr, i_mwr, i_mclr;
  logic [31:0] i_stat = '0, i_mask = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .irq_mode_o(i_mode), .irq_invert_o(i_inv),
    .irq_edge_o(i_edge), .irq_both_o(i_both), .irq_clr_o(i_clr),
    .irq_msk_wr_o(i_mwr), .irq_msk_clr_o(i_mclr),
    .irq_status_i(i_stat), .irq_mask_i(i_mask)
  );

  // {addr, wdata, expected read-back}
  localparam logic [71:0] VEC [10] = '{
    {8'h00, 32'h0000_00F0, 32'h0000_00F0},  // R2 mode
    {8'h04, 32'h0000_0FF0, 32'h0000_0FF0},  // R2 direction
    {8'h08, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R2 output data
    {8'h20, 32'h0000_0000, 32'h0000_0000},  // R2 polarity
    {8'h24, 32'h1234_5678, 32'h1234_5678},  // R2 edge/level
    {8'h28, 32'hFFFF_0000, 32'hFFFF_0000},  // R2 debounce
    {8'h40, 32'h0000_0300, 32'h0000_0300},  // R2 drive select
    {8'h4C, 32'h8000_0001, 32'h8000_0001},  // R2 both-edge
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},  // R6 input is read-only
    {8'h30, 32'hDEAD_BEEF, 32'h0000_0000}   // R11 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_o", pad_out, 32'h0);
    rd(8'h00, v); chk("R1 mode", v, 32'h0);
    rd(8'h04, v); chk("R1 dir", v, 32'h0);
    rd(8'h08, v); chk("R1 dout", v, 32'h0);
    rd(8'h4C, v); chk("R1 both", v, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk((i >= 9) ? "R11 table" : (i == 8) ? "R6 table" : "R2 table", v, VEC[i][31:0]);
    end
    rd(8'h00, v); chk("R11 mode kept", v, 32'h0000_00F0);

    chk("R3 pad_oe", pad_oe, 32'h0000_0F00);
    chk("R4 pad_o", pad_out, 32'hA5A5_585A);
    chk("R9 mode", i_mode, 32'h0000_00F0);
    chk("R9 invert", i_inv, 32'h0);
    chk("R9 edge", i_edge, 32'h1234_5678);
    chk("R9 both", i_both, 32'h8000_0001);

    // R5 synchroniser latency
    pad_in = 32'h0F0F_0000;
    @(negedge clk); rd(8'h0C, v); chk("R5 hidden after 1 edge", v, 32'h0);
    @(negedge clk); rd(8'h0C, v); chk("R5 visible after 2 edges", v, 32'h0F0F_0000);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h0C, v); chk("R5 negative logic", v, 32'h0F0F_FFFF);
    chk("R9 invert", i_inv, 32'h0000_FFFF);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, v); chk("R6 write ignored", v, 32'h0F0F_FFFF);

    // R10 debounce has no effect
    wr(8'h28, 32'h0000_0000);
    chk("R10 pad_oe", pad_oe, 32'h0000_0F00);
    chk("R10 pad_o", pad_out, 32'hA5A5_585A);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R10 input", v, 32'h0F0F_FFFF);
    chk("R10 pad_o", pad_out, 32'hA5A5_585A);

    // R7 strobes
    wr(8'h14, 32'h0000_0055);
    chk("R7 clr", i_clr, 32'h55); chk("R7 mwr idle", i_mwr, 32'h0);
    @(negedge clk); chk("R7 clr drop", i_clr, 32'h0);
    wr(8'h18, 32'h0000_AA00);
    chk("R7 mwr", i_mwr, 32'hAA00); chk("R7 mclr idle", i_mclr, 32'h0);
    @(negedge clk); chk("R7 mwr drop", i_mwr, 32'h0);
    wr(8'h1C, 32'h8000_0000);
    chk("R7 mclr", i_mclr, 32'h8000_0000); chk("R7 clr idle", i_clr, 32'h0);
    @(negedge clk); chk("R7 mclr drop", i_mclr, 32'h0);

    // R8 readback from interrupt unit
    i_stat = 32'h0000_1111; i_mask = 32'h2222_0000;
    rd(8'h10, v); chk("R8 status", v, 32'h0000_1111);
    rd(8'h18, v); chk("R8 mask", v, 32'h2222_0000);
    rd(8'h1C, v); chk("R11 mask-clear read", v, 32'h0);

    // R3 interrupt mode overrides direction
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R3 irq mode no drive", pad_oe, 32'h0);
    wr(8'h00, 32'h0);
    chk("R3 all general", pad_oe, 32'h0000_0FF0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule